// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block runs IEEE 802.3 Clause 45 management frames on an MDIO bus toward external PHYs. Software works through four 32-bit registers selected by a 2-bit index: status/configuration (0), control (1), data (2) and address (3). The master derives MDC from the system clock and drives MDIO through an output enable, so the pad can be shared with the PHYs.

Each access has two phases, and software starts each one. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing the control register with its command bit set sends a read frame. The address phase shows busy in status bit 0, and the data phase shows busy in data bit 31. A read that gets no answer from a PHY during turnaround sets a read-error flag and returns all ones.

Top module: `mdio45_master`

## Requirements
- R1: After reset, all four registers read as zero, MDC is low and the MDIO output enable is low.
- R2: MDC stays low while no frame is active. During a frame each MDC half period lasts (D+1) clock cycles, where D is status bits 15:8 as last written.
- R3: The MDIO output and its enable change only at the start of a frame or with a falling MDC edge. They never change at a rising MDC edge.
- R4: A frame begins with 32 preamble ones, unless control bit 10 was set when the frame started. In that case the frame is 32 bits long with no preamble.
- R5: After the preamble the bits go out MSB first: start 00, 2-bit opcode, port address (control bits 9:5), device address (control bits 4:0), turnaround 10 on non-read frames, then 16 bits of payload.
- R6: Writing register 3 stores its 16 bits and sends an address frame with opcode 00 carrying them. Status bit 0 reads 1 from the write until the frame has ended.
- R7: Writing register 2 stores its 16 bits and sends a write frame with opcode 01 carrying them. Data bit 31 reads 1 until that frame has ended.
- R8: Writing register 1 stores bits 14:0. If bit 15 is also set, a read frame goes out with opcode 11, or opcode 10 when bit 14 is set. Control bit 15 always reads back as 0.
- R9: During a read frame the output enable is low for both turnaround bits and all 16 data bits. MDIO is sampled at each rising MDC edge in the data field, MSB first, into data bits 15:0. Data bit 31 stays 1 until the value has been stored.
- R10: If MDIO is 1 at the rising edge of the second turnaround bit of a read, status bit 1 is set and data bits 15:0 become FFFF. Starting the next read clears status bit 1.
- R11: A register write made while status bit 0 or data bit 31 is 1 has no effect on any register or on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register index for writes |
| regWdata | input | 16 | Write data |
| rdSel | input | 2 | Register index for reads |
| rdData | output | 32 | Read data of the register picked by rdSel |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
The bench runs three divider settings and compares the MDC half period against them. A divider that is off by one or doubled gives a period that does not match. It sends frames with and without preamble. A wrong frame length, opcode or field order then shows up as bit mismatches against the decoded frame.

Reads are tried with a PHY that answers, and with a floating line that leaves the second turnaround bit at 1. A design that ignores that bit would return stale data and no error flag. A design that drives during turnaround would show the output enable at the wrong time.

Writes are also issued while a frame is in flight. A master that accepts them would corrupt the stored address or restart the bus mid-frame.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 16;
  localparam int DIV_W      = 8;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 2 + 2 + PHY_W + PHY_W + 2;
  localparam int FRAME_BITS = HDR_BITS + REG_W;
  localparam int ALL_BITS   = PRE_BITS + FRAME_BITS;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_ADDR = 2'd3
  } regSel_e;

  // launch request handed from control to datapath
  typedef struct packed {
    logic             go;
    logic             rd;
    logic             pre;
    logic [1:0]       op;
    logic [PHY_W-1:0] prt;
    logic [PHY_W-1:0] dev;
    logic [REG_W-1:0] payload;
  } cmd_t;
endpackage

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
  import mdio45_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWdata,
  input  logic [1:0]       rdSel,
  output logic [31:0]      rdData,
  input  logic             frameDone,
  input  logic             rdBad,
  input  logic [REG_W-1:0] rdWord,
  output cmd_t             cmd,
  output logic [DIV_W-1:0] divHalf,
  output logic             adrBusy,
  output logic             dataBusy
);
  logic [14:0]      ctrlReg;
  logic [REG_W-1:0] dataReg;
  logic [REG_W-1:0] addrReg;
  logic             rdErr;
  logic             readPend;
  logic             busy;

  assign busy = adrBusy | dataBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      dataReg  <= '0;
      addrReg  <= '0;
      divHalf  <= '0;
      rdErr    <= 1'b0;
      readPend <= 1'b0;
      adrBusy  <= 1'b0;
      dataBusy <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.go <= 1'b0;
      if (frameDone) begin
        adrBusy  <= 1'b0;
        dataBusy <= 1'b0;
        if (readPend) begin
          readPend <= 1'b0;
          rdErr    <= rdBad;
          dataReg  <= rdBad ? '1 : rdWord;
        end
      end else if (regWe && !busy) begin
        case (regSel)
          SEL_STAT: divHalf <= regWdata[15:8];
          SEL_CTRL: begin
            ctrlReg <= regWdata[14:0];
            if (regWdata[15]) begin
              dataBusy <= 1'b1;
              readPend <= 1'b1;
              rdErr    <= 1'b0;
              cmd <= '{go: 1'b1, rd: 1'b1, pre: !regWdata[10],
                       op: (regWdata[14] ? 2'b10 : 2'b11),
                       prt: regWdata[9:5], dev: regWdata[4:0], payload: '1};
            end
          end
          SEL_DATA: begin
            dataReg  <= regWdata;
            dataBusy <= 1'b1;
            cmd <= '{go: 1'b1, rd: 1'b0, pre: !ctrlReg[10], op: 2'b01,
                     prt: ctrlReg[9:5], dev: ctrlReg[4:0], payload: regWdata};
          end
          default: begin
            addrReg <= regWdata;
            adrBusy <= 1'b1;
            cmd <= '{go: 1'b1, rd: 1'b0, pre: !ctrlReg[10], op: 2'b00,
                     prt: ctrlReg[9:5], dev: ctrlReg[4:0], payload: regWdata};
          end
        endcase
      end
    end
  end

  always_comb begin
    case (rdSel)
      SEL_STAT: rdData = {16'h0, divHalf, 6'b0, rdErr, adrBusy};
      SEL_CTRL: rdData = {16'h0, 1'b0, ctrlReg};
      SEL_DATA: rdData = {dataBusy, 15'b0, dataReg};
      default:  rdData = {16'h0, addrReg};
    endcase
  end
endmodule

// File: rtl/mdio45_datapath.sv
module mdio45_datapath
  import mdio45_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmd_t             cmd,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             frameDone,
  output logic             rdBad,
  output logic [REG_W-1:0] rdWord
);
  localparam int LEFT_W  = $clog2(ALL_BITS + 1);
  localparam int TA1_LEFT = REG_W + 2;
  localparam int TA2_LEFT = REG_W + 1;

  logic                  active;
  logic                  isRead;
  logic [DIV_W-1:0]      tick;
  logic [ALL_BITS-1:0]   shifter;
  logic [LEFT_W-1:0]     left;
  logic [FRAME_BITS-1:0] frameWord;

  assign frameWord = {2'b00, cmd.op, cmd.prt, cmd.dev, 2'b10, cmd.payload};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isRead    <= 1'b0;
      tick      <= '0;
      mdc       <= 1'b0;
      shifter   <= '0;
      left      <= '0;
      frameDone <= 1'b0;
      rdBad     <= 1'b0;
      rdWord    <= '0;
    end else begin
      frameDone <= 1'b0;
      if (cmd.go) begin
        active  <= 1'b1;
        isRead  <= cmd.rd;
        tick    <= '0;
        mdc     <= 1'b0;
        rdBad   <= 1'b0;
        rdWord  <= '0;
        left    <= cmd.pre ? LEFT_W'(ALL_BITS) : LEFT_W'(FRAME_BITS);
        shifter <= cmd.pre ? {{PRE_BITS{1'b1}}, frameWord}
                           : {frameWord, {PRE_BITS{1'b0}}};
      end else if (active) begin
        if (tick == divHalf) begin
          tick <= '0;
          mdc  <= ~mdc;
          if (!mdc) begin
            // rising edge: sample
            if (isRead && left == LEFT_W'(TA2_LEFT)) rdBad <= mdioIn;
            if (isRead && left <= LEFT_W'(REG_W)) rdWord <= {rdWord[REG_W-2:0], mdioIn};
          end else begin
            // falling edge: advance
            shifter <= shifter << 1;
            left    <= left - 1'b1;
            if (left == LEFT_W'(1)) begin
              active    <= 1'b0;
              frameDone <= 1'b1;
            end
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign mdioOut = shifter[ALL_BITS-1];
  assign mdioOe  = active && !(isRead && left <= LEFT_W'(TA1_LEFT));
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWdata,
  input  logic [1:0]       rdSel,
  output logic [31:0]      rdData,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  cmd_t             cmd;
  logic [DIV_W-1:0] divHalf;
  logic             adrBusy;
  logic             dataBusy;
  logic             frameDone;
  logic             rdBad;
  logic [REG_W-1:0] rdWord;

  mdio45_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .rdSel(rdSel), .rdData(rdData), .frameDone(frameDone), .rdBad(rdBad),
    .rdWord(rdWord), .cmd(cmd), .divHalf(divHalf), .adrBusy(adrBusy),
    .dataBusy(dataBusy)
  );

  mdio45_datapath uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divHalf(divHalf), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .frameDone(frameDone),
    .rdBad(rdBad), .rdWord(rdWord)
  );
endmodule

// File: rtl/mdio45_checker.sv
module mdio45_checker (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic adrBusy,
  input logic dataBusy,
  input logic frameDone
);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !(adrBusy || dataBusy) |-> !mdc);

  a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe)));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (adrBusy && !frameDone) |=> adrBusy);

  a_r9_oe_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> (adrBusy || dataBusy));

  a_r11_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    !(adrBusy && dataBusy));
endmodule

bind mdio45_master mdio45_checker uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .adrBusy(adrBusy), .dataBusy(dataBusy), .frameDone(frameDone)
);

// File: tb/sim_mdio45_master.sv
`timescale 1ns/1ps
module sim_mdio45_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = 16'h0;
  logic [1:0]  rdSel = 2'd0;
  logic [31:0] rdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int r3Viol = 0;

  always #5 clk = ~clk;

  mdio45_master u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .rdSel(rdSel), .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  // reference model state
  logic [7:0]  mDiv;
  logic [14:0] mCtl;
  logic [15:0] mData, mAddr, mRd;
  bit mAdrBusy, mDataBusy, mErr, mReadPend, mFin, mPend, mAct, mMdc, mRead, mTaBad;
  int mCnt, mLeft;
  bit q[$];
  bit pPre, pRead;
  logic [1:0] pOp;
  logic [4:0] pPrt, pDev;
  logic [15:0] pPay;

  // PHY stimulus
  logic [15:0] phyWord = 16'h0;
  bit phyTa = 1'b0;

  // capture of bits at rising MDC
  bit capQ[$];
  bit capOe[$];
  int riseCyc[$];
  bit prevMdc = 1'b0;
  bit prevOut = 1'b0;

  always @(posedge clk) begin
    bit accept, finNow;
    cyc++;
    if (!rstN) begin
      mDiv = 0; mCtl = 0; mData = 0; mAddr = 0; mRd = 0;
      mAdrBusy = 0; mDataBusy = 0; mErr = 0; mReadPend = 0; mFin = 0;
      mPend = 0; mAct = 0; mMdc = 0; mRead = 0; mTaBad = 0; mCnt = 0; mLeft = 0;
      q.delete();
    end else begin
      accept = regWe && !(mAdrBusy || mDataBusy);
      finNow = mFin;
      mFin = 0;
      // bus engine
      if (mPend) begin
        mPend = 0; mAct = 1; mMdc = 0; mCnt = 0; mRead = pRead; mTaBad = 0; mRd = 0;
        q.delete();
        if (pPre) repeat (32) q.push_back(1'b1);
        q.push_back(1'b0); q.push_back(1'b0);
        q.push_back(pOp[1]); q.push_back(pOp[0]);
        for (int i = 4; i >= 0; i--) q.push_back(pPrt[i]);
        for (int i = 4; i >= 0; i--) q.push_back(pDev[i]);
        q.push_back(1'b1); q.push_back(1'b0);
        for (int i = 15; i >= 0; i--) q.push_back(pPay[i]);
        mLeft = q.size();
      end else if (mAct) begin
        if (mCnt == int'(mDiv)) begin
          mCnt = 0;
          if (!mMdc) begin
            mMdc = 1;
            if (mRead && mLeft == 17) mTaBad = mdioIn;
            if (mRead && mLeft <= 16) mRd = {mRd[14:0], mdioIn};
          end else begin
            mMdc = 0;
            void'(q.pop_front());
            mLeft--;
            if (mLeft == 0) begin mAct = 0; mFin = 1; end
          end
        end else mCnt++;
      end
      // register side
      if (finNow) begin
        mAdrBusy = 0; mDataBusy = 0;
        if (mReadPend) begin
          mReadPend = 0; mErr = mTaBad;
          mData = mTaBad ? 16'hFFFF : mRd;
        end
      end else if (accept) begin
        case (regSel)
          2'd0: mDiv = regWdata[15:8];
          2'd1: begin
            mCtl = regWdata[14:0];
            if (regWdata[15]) begin
              mDataBusy = 1; mReadPend = 1; mErr = 0; mPend = 1;
              pPre = !regWdata[10]; pRead = 1; pOp = regWdata[14] ? 2'b10 : 2'b11;
              pPrt = regWdata[9:5]; pDev = regWdata[4:0]; pPay = 16'hFFFF;
            end
          end
          2'd2: begin
            mData = regWdata; mDataBusy = 1; mPend = 1;
            pPre = !mCtl[10]; pRead = 0; pOp = 2'b01;
            pPrt = mCtl[9:5]; pDev = mCtl[4:0]; pPay = regWdata;
          end
          default: begin
            mAddr = regWdata; mAdrBusy = 1; mPend = 1;
            pPre = !mCtl[10]; pRead = 0; pOp = 2'b00;
            pPrt = mCtl[9:5]; pDev = mCtl[4:0]; pPay = regWdata;
          end
        endcase
      end
    end
  end

  function automatic logic [31:0] expReg(input logic [1:0] s);
    case (s)
      2'd0:    return {16'h0, mDiv, 6'b0, mErr, mAdrBusy};
      2'd1:    return {16'h0, 1'b0, mCtl};
      2'd2:    return {mDataBusy, 15'b0, mData};
      default: return {16'h0, mAddr};
    endcase
  endfunction

  task automatic fail(input string tag, input logic [31:0] act, input logic [31:0] exp);
    bad++;
    $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) fail(tag, act, exp);
  endtask

  // per-clock comparison and PHY drive, away from the edge
  always @(posedge clk) begin
    bit expOe;
    #3;
    if (rstN) begin
      expOe = mAct && !(mRead && mLeft <= 18);
      total++;
      if (mdc !== mMdc) fail("R2 mdc", {31'b0, mdc}, {31'b0, mMdc});
      else if (mdioOe !== expOe) fail("R9 oe", {31'b0, mdioOe}, {31'b0, expOe});
      else if (expOe && q.size() > 0 && mdioOut !== q[0]) fail("R5 bit", {31'b0, mdioOut}, {31'b0, q[0]});
      else if (rdData !== expReg(rdSel)) fail("R11 reg", rdData, expReg(rdSel));
      if (mdc && !prevMdc) begin
        capQ.push_back(mdioOut); capOe.push_back(mdioOe); riseCyc.push_back(cyc);
        if (mdioOut !== prevOut) r3Viol++;
      end
      prevMdc = mdc; prevOut = mdioOut;
      if (mAct && mRead && mLeft == 17) mdioIn = phyTa;
      else if (mAct && mRead && mLeft >= 1 && mLeft <= 16) mdioIn = phyWord[mLeft-1];
      else mdioIn = 1'b1;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); regWe = 1'b1; regSel = s; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic getReg(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rdSel = s; #1 v = rdData;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end while ((mAdrBusy || mDataBusy || mPend) && n < 20000);
    @(negedge clk);
  endtask

  task automatic capClr();
    capQ.delete(); capOe.delete(); riseCyc.delete();
  endtask

  function automatic logic [31:0] capBits(input int from, input int n);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v = {v[30:0], capQ[from+i]};
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin getReg(2'(s), v); chk("R1 reg", v, 32'h0); end
    chk("R1 mdc", {31'b0, mdc}, 32'h0);
    chk("R1 oe", {31'b0, mdioOe}, 32'h0);

    // divider 1, port 5, device 3
    wr(2'd0, 16'h0100); getReg(2'd0, v); chk("R2 div field", v, 32'h0000_0100);
    wr(2'd1, 16'h00A3); getReg(2'd1, v); chk("R8 ctrl readback", v, 32'h0000_00A3);

    // R6 address frame, R11 write during busy
    capClr();
    wr(2'd3, 16'h1234);
    getReg(2'd0, v); chk("R6 busy set", {31'b0, v[0]}, 32'h1);
    wr(2'd3, 16'h5555);
    wr(2'd0, 16'h0700);
    waitIdle();
    getReg(2'd3, v); chk("R11 addr kept", v, 32'h0000_1234);
    getReg(2'd0, v); chk("R11 div kept and R6 busy clear", v, 32'h0000_0100);
    chk("R4 preamble length", capQ.size(), 64);
    chk("R4 preamble ones", capBits(0, 32), 32'hFFFF_FFFF);
    chk("R6 opcode", capBits(34, 2), 32'h0);
    chk("R5 header", capBits(32, 16), {16'h0, 2'b00, 2'b00, 5'd5, 5'd3, 2'b10});
    chk("R5 payload", capBits(48, 16), 32'h0000_1234);
    chk("R2 period d1", riseCyc[1] - riseCyc[0], 4);

    // R7 write frame without preamble, divider 0
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h04A3);
    capClr();
    wr(2'd2, 16'hBEEF);
    getReg(2'd2, v); chk("R7 data busy", {31'b0, v[31]}, 32'h1);
    waitIdle();
    chk("R4 no preamble", capQ.size(), 32);
    chk("R7 opcode", capBits(2, 2), 32'h1);
    chk("R7 payload", capBits(16, 16), 32'h0000_BEEF);
    getReg(2'd2, v); chk("R7 data done", v, 32'h0000_BEEF);
    chk("R2 period d0", riseCyc[1] - riseCyc[0], 2);

    // R9 good read, divider 3
    wr(2'd0, 16'h0300);
    wr(2'd1, 16'h00A3);
    phyWord = 16'hA5C3; phyTa = 1'b0;
    capClr();
    wr(2'd1, 16'h80A3);
    getReg(2'd2, v); chk("R9 read busy", {31'b0, v[31]}, 32'h1);
    getReg(2'd1, v); chk("R8 cmd bit reads 0", v, 32'h0000_00A3);
    waitIdle();
    getReg(2'd2, v); chk("R9 read data", v, 32'h0000_A5C3);
    getReg(2'd0, v); chk("R10 no error", {31'b0, v[1]}, 32'h0);
    chk("R9 oe off in turnaround", {31'b0, capOe[46]}, 32'h0);
    chk("R8 read opcode", capBits(34, 2), 32'h3);
    chk("R2 period d3", riseCyc[1] - riseCyc[0], 8);

    // R10 missing PHY
    phyTa = 1'b1;
    wr(2'd1, 16'h80A3);
    waitIdle();
    getReg(2'd2, v); chk("R10 ones returned", v, 32'h0000_FFFF);
    getReg(2'd0, v); chk("R10 error set", {31'b0, v[1]}, 32'h1);

    // R8 post-increment read, error cleared
    phyTa = 1'b0; phyWord = 16'h0F0F;
    wr(2'd0, 16'h0100);
    capClr();
    wr(2'd1, 16'hC0A3);
    getReg(2'd0, v); chk("R10 error cleared at start", {31'b0, v[1]}, 32'h0);
    waitIdle();
    chk("R8 post-inc opcode", capBits(34, 2), 32'h2);
    getReg(2'd2, v); chk("R9 post-inc data", v, 32'h0000_0F0F);
    getReg(2'd1, v); chk("R8 post-inc stored", v, 32'h0000_40A3);
    chk("R3 no change at rise", r3Viol, 0);
    chk("R2 idle low", {31'b0, mdc}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule